// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block feeds a display pipeline from memory without processor involvement per frame. Each frame is described by a four-word record that memory holds. The record gives the address of the following record, the frame buffer address, a frame identifier and a command word. The command word carries the frame length in 32-bit words and the per-frame interrupt requests. The fetcher reads a record and keeps its fields in registers that software can read. It then pulls the frame's pixel words in bursts and hands them to the display FIFO. When the frame is complete, it follows the link to the next record. A record that links to itself refreshes the same buffer for as long as the block stays enabled.

The memory side has two channels. The request channel carries an address and a word count, and uses valid/ready. The response channel returns one word per handshake, also with valid/ready. Pixel words leave on a valid/ready stream. When the pixel consumer deasserts `px_ready`, the block deasserts `rsp_ready` in the same cycle, so back-pressure passes straight through to memory. A request, once valid, keeps its address and length until it is accepted.

Software supplies the following through plain control pins:
- the first record address;
- the burst size code;
- the three interrupt enables.

It clears the three sticky flags with per-flag clear pulses.

Top module: `dfetch_top`

## Requirements
- R1: After reset the block is idle: `busy`, `mreq_valid` and all three flags are 0.
- R2: A record is read with one request of length 4 at the record address. The four words arrive in this order: link, buffer address, frame ID, command. The last three are readable on `src_addr_q`, `frame_id_q` and `cmd_q`.
- R3: The burst size code `burst_sel` is decoded as follows: 0 selects 4 words, 1 selects 8 words, and 2 or 3 select 16 words. No pixel request is longer than the selected size, and no pixel request has length zero.
- R4: When fewer words remain than the burst size, the last request of the frame asks for exactly the remainder.
- R5: The frame length is command bits 11:0, counted in words. Pixel words are requested at byte addresses that start at the buffer address and step by 4. They leave on `px_data` in that order, with none dropped or repeated.
- R6: A pixel burst is requested only when `fifo_free` is at least the length of that burst. Until then the block waits.
- R7: The next record is requested only after the last pixel word of the current frame has been accepted. The next record address is the link field, and `desc_addr_q` shows it. A record that links to itself repeats its frame.
- R8: The start-of-frame flag is set when a record whose command bit 15 is 1 has been read and `sof_ie` is 1. The end-of-frame flag is set when a frame whose command bit 16 is 1 completes and `eof_ie` is 1. Neither flag is set while its enable is 0.
- R9: The underrun flag is set when `fifo_empty` is 1 while pixel words of the current frame are still owed and `ufl_ie` is 1. It is not set when `ufl_ie` is 0.
- R10: A flag stays at 1 until its clear input is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R11: A pixel stall (`px_ready` low) pauses the frame without losing or reordering words. A valid request holds its address and length until `mreq_ready`.
- R12: Raising `enable` while idle starts a fetch at `start_addr`. Dropping `enable` stops the block at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request |
| burst_sel | input | 2 | Burst size code |
| sof_ie | input | 1 | Start-of-frame interrupt enable |
| eof_ie | input | 1 | End-of-frame interrupt enable |
| ufl_ie | input | 1 | Underrun reporting enable |
| start_addr | input | AW | First record address |
| fifo_free | input | FREE_W | Free slots in display FIFO |
| fifo_empty | input | 1 | Display FIFO is empty |
| clr_sof | input | 1 | Clear start-of-frame flag |
| clr_eof | input | 1 | Clear end-of-frame flag |
| clr_ufl | input | 1 | Clear underrun flag |
| mreq_valid | output | 1 | Read request valid |
| mreq_ready | input | 1 | Read request accepted |
| mreq_addr | output | AW | Read byte address |
| mreq_len | output | 5 | Read length in words |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Read data accepted |
| rsp_data | input | 32 | Read data word |
| px_valid | output | 1 | Pixel word valid |
| px_ready | input | 1 | Pixel consumer ready |
| px_data | output | 32 | Pixel word |
| desc_addr_q | output | AW | Current or next record address |
| src_addr_q | output | AW | Frame buffer address from record |
| frame_id_q | output | 32 | Frame ID from record |
| cmd_q | output | 32 | Command word from record |
| busy | output | 1 | Not idle |
| sof_flag | output | 1 | Start-of-frame flag |
| eof_flag | output | 1 | End-of-frame flag |
| ufl_flag | output | 1 | Underrun flag |

## Verification
Two functions can collide in the same cycle: an end-of-frame flag set by a completing frame, and a software clear of that same flag. The bench provokes the collision by holding `clr_eof` high for the whole of a frame. It judges the outcome by checking two things: that `eof_flag` is seen high exactly once after the frame completes, and that it is low again afterwards. A second overlap also gets checked: back-pressure on the pixel stream arrives while a burst is in flight. The bench alternates `px_ready` and requires the words to arrive complete and in order.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
  localparam int WORD_W     = 32;
  localparam int BL_W       = 5;
  localparam int DESC_WORDS = 4;
  localparam int SOF_BIT    = 15;
  localparam int EOF_BIT    = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DRSP, S_BWAIT, S_BREQ, S_BRSP
  } fetch_st_e;

  function automatic logic [BL_W-1:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return BL_W'(4);
      2'd1:    return BL_W'(8);
      default: return BL_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/dfetch_burst_sizer.sv
module dfetch_burst_sizer
  import dfetch_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [1:0]       burst_sel,
  input  logic [LEN_W-1:0] remaining,
  output logic [BL_W-1:0]  blen
);
  logic [BL_W-1:0] full_len;
  always_comb begin
    full_len = burst_words(burst_sel);
    // final burst shrinks to whatever is left
    if (remaining < LEN_W'(full_len)) blen = remaining[BL_W-1:0];
    else                              blen = full_len;
  end
endmodule

// File: rtl/dfetch_irq_flags.sv
module dfetch_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]);
    // R10
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/dfetch_seq.sv
module dfetch_seq
  import dfetch_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 12,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        burst_sel,
  input  logic              sof_ie,
  input  logic              eof_ie,
  input  logic              ufl_ie,
  input  logic [AW-1:0]     start_addr,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              fifo_empty,
  input  logic [BL_W-1:0]   blen,
  output logic [LEN_W-1:0]  rem_o,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [AW-1:0]     mreq_addr,
  output logic [BL_W-1:0]   mreq_len,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [WORD_W-1:0] px_data,
  output logic [AW-1:0]     desc_addr_q,
  output logic [AW-1:0]     src_addr_q,
  output logic [WORD_W-1:0] frame_id_q,
  output logic [WORD_W-1:0] cmd_q,
  output logic              busy,
  output logic              sof_set,
  output logic              eof_set,
  output logic              ufl_set
);
  fetch_st_e         state;
  logic [AW-1:0]     link_q, cur_addr;
  logic [LEN_W-1:0]  rem;
  logic [BL_W-1:0]   req_len, bcnt;
  logic [1:0]        widx;
  logic              room;

  assign rem_o = rem;
  assign room  = 32'(fifo_free) >= 32'(blen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  desc_addr_q <= '0; link_q <= '0; src_addr_q <= '0;
      frame_id_q <= '0; cmd_q <= '0; cur_addr <= '0; rem <= '0;
      req_len <= '0; bcnt <= '0; widx <= '0;
    end else begin
      case (state)
        S_IDLE: if (enable) begin
          desc_addr_q <= start_addr;
          state       <= S_DREQ;
        end
        S_DREQ: if (mreq_ready) begin
          widx  <= '0;
          state <= S_DRSP;
        end
        S_DRSP: if (rsp_valid) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: link_q     <= rsp_data[AW-1:0];
            2'd1: src_addr_q <= rsp_data[AW-1:0];
            2'd2: frame_id_q <= rsp_data;
            default: begin
              cmd_q    <= rsp_data;
              rem      <= rsp_data[LEN_W-1:0];
              cur_addr <= src_addr_q;
              state    <= S_BWAIT;
            end
          endcase
        end
        S_BWAIT: begin
          if (rem == '0) begin
            desc_addr_q <= link_q;
            state       <= enable ? S_DREQ : S_IDLE;
          end else if (room) begin
            req_len <= blen;
            state   <= S_BREQ;
          end
        end
        S_BREQ: if (mreq_ready) begin
          bcnt  <= req_len;
          state <= S_BRSP;
        end
        S_BRSP: if (rsp_valid && px_ready) begin
          cur_addr <= cur_addr + AW'(4);
          rem      <= rem - LEN_W'(1);
          bcnt     <= bcnt - BL_W'(1);
          if (bcnt == BL_W'(1)) state <= S_BWAIT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mreq_valid = (state == S_DREQ) || (state == S_BREQ);
    mreq_addr  = (state == S_DREQ) ? desc_addr_q : cur_addr;
    mreq_len   = (state == S_DREQ) ? BL_W'(DESC_WORDS) : req_len;
    rsp_ready  = (state == S_DRSP) || ((state == S_BRSP) && px_ready);
    px_valid   = (state == S_BRSP) && rsp_valid;
    px_data    = rsp_data;
    busy       = state != S_IDLE;
    sof_set    = (state == S_DRSP) && rsp_valid && (widx == 2'd3)
                 && rsp_data[SOF_BIT] && sof_ie;
    eof_set    = (state == S_BWAIT) && (rem == '0) && cmd_q[EOF_BIT] && eof_ie;
    ufl_set    = ufl_ie && fifo_empty && (rem != '0) &&
                 ((state == S_BWAIT) || (state == S_BREQ) || (state == S_BRSP));
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_len)));
  // R6
  room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BREQ && $past(state) == S_BWAIT) |-> 32'($past(fifo_free)) >= 32'(mreq_len));
  // R3
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BREQ) |-> (mreq_len != '0 && mreq_len <= burst_words(burst_sel)));
  // R7
  desc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DREQ) |-> (rem == '0));
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
  import dfetch_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 12,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        burst_sel,
  input  logic              sof_ie,
  input  logic              eof_ie,
  input  logic              ufl_ie,
  input  logic [AW-1:0]     start_addr,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              fifo_empty,
  input  logic              clr_sof,
  input  logic              clr_eof,
  input  logic              clr_ufl,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [AW-1:0]     mreq_addr,
  output logic [4:0]        mreq_len,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [31:0]       px_data,
  output logic [AW-1:0]     desc_addr_q,
  output logic [AW-1:0]     src_addr_q,
  output logic [31:0]       frame_id_q,
  output logic [31:0]       cmd_q,
  output logic              busy,
  output logic              sof_flag,
  output logic              eof_flag,
  output logic              ufl_flag
);
  logic [BL_W-1:0]  blen;
  logic [LEN_W-1:0] rem;
  logic             sof_set, eof_set, ufl_set;
  logic [2:0]       flags;

  dfetch_burst_sizer #(.LEN_W(LEN_W)) u_sizer (
    .burst_sel(burst_sel), .remaining(rem), .blen(blen)
  );

  dfetch_seq #(.AW(AW), .LEN_W(LEN_W), .FREE_W(FREE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .burst_sel(burst_sel),
    .sof_ie(sof_ie), .eof_ie(eof_ie), .ufl_ie(ufl_ie), .start_addr(start_addr),
    .fifo_free(fifo_free), .fifo_empty(fifo_empty), .blen(blen), .rem_o(rem),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mreq_len(mreq_len), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .px_valid(px_valid), .px_ready(px_ready),
    .px_data(px_data), .desc_addr_q(desc_addr_q), .src_addr_q(src_addr_q),
    .frame_id_q(frame_id_q), .cmd_q(cmd_q), .busy(busy),
    .sof_set(sof_set), .eof_set(eof_set), .ufl_set(ufl_set)
  );

  dfetch_irq_flags #(.N(3)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_i({ufl_set, eof_set, sof_set}),
    .clr_i({clr_ufl, clr_eof, clr_sof}),
    .flag_o(flags)
  );

  assign sof_flag = flags[0];
  assign eof_flag = flags[1];
  assign ufl_flag = flags[2];
endmodule

// File: tb/dfetch_top_tb.sv
module dfetch_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        enable = 0, sof_ie = 0, eof_ie = 0, ufl_ie = 0;
  logic [1:0]  burst_sel = 0;
  logic [31:0] start_addr = 0;
  logic [5:0]  fifo_free = 6'd32;
  logic        fifo_empty = 0, clr_sof = 0, clr_eof = 0, clr_ufl = 0;
  logic        mreq_valid, mreq_ready, rsp_valid, rsp_ready, px_valid, px_ready;
  logic [31:0] mreq_addr, rsp_data, px_data, desc_addr_q, src_addr_q, frame_id_q, cmd_q;
  logic [4:0]  mreq_len;
  logic        busy, sof_flag, eof_flag, ufl_flag;
  logic        px_rdy = 1, bp_mode = 0;

  dfetch_top u_dut (.*);

  // memory model
  logic [31:0] mem [256];
  logic [31:0] m_ptr;
  logic [4:0]  m_left;
  assign mreq_ready = (m_left == 0);
  assign rsp_valid  = (m_left != 0);
  assign rsp_data   = mem[m_ptr[9:2]];
  assign px_ready   = px_rdy;

  always @(posedge clk) begin
    if (!rst_n) m_left <= 0;
    else if (m_left == 0 && mreq_valid) begin m_ptr <= mreq_addr; m_left <= mreq_len; end
    else if (rsp_valid && rsp_ready) begin m_ptr <= m_ptr + 4; m_left <= m_left - 1; end
  end

  int checks = 0, errors = 0, cyc = 0;
  int bursts, last_len, desc_reqs, px_n, px_bad, order_bad, order_mod, eof_seen;
  logic [31:0] exp_px [128];

  always @(posedge clk) if (rst_n) begin
    if (mreq_valid && mreq_ready) begin
      if (mreq_addr < 32'h100) begin
        desc_reqs++;
        if (px_n % order_mod != 0) order_bad++;
      end else begin bursts++; last_len = int'(mreq_len); end
    end
    if (px_valid && px_ready) begin
      if (px_data !== exp_px[px_n]) px_bad++;
      px_n++;
    end
  end
  always @(negedge clk) begin
    if (eof_flag) eof_seen++;
    if (bp_mode) px_rdy <= ~px_rdy;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic clr_cnt();
    bursts = 0; last_len = 0; desc_reqs = 0; px_n = 0; px_bad = 0;
    order_bad = 0; order_mod = 1; eof_seen = 0;
  endtask

  task automatic put_desc(input int at, input logic [31:0] nxt, src, id, cmd);
    mem[at/4] = nxt; mem[at/4+1] = src; mem[at/4+2] = id; mem[at/4+3] = cmd;
  endtask

  task automatic fill_exp(input int off, input logic [31:0] src, input int len);
    for (int k = 0; k < len; k++) exp_px[off+k] = mem[src[9:2] + k];
  endtask

  task automatic kick();
    @(negedge clk) enable = 1;
    @(negedge clk) enable = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    clr_sof = (which == 0); clr_eof = (which == 1); clr_ufl = (which == 2);
    @(negedge clk);
    clr_sof = 0; clr_eof = 0; clr_ufl = 0;
  endtask

  typedef struct packed {
    logic [11:0] len; logic [1:0] sel; logic [7:0] nb; logic [4:0] last;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{12'd10, 2'd0, 8'd3, 5'd2},
    '{12'd16, 2'd1, 8'd2, 5'd8},
    '{12'd20, 2'd2, 8'd2, 5'd4},
    '{12'd3,  2'd2, 8'd1, 5'd3},
    '{12'd32, 2'd3, 8'd2, 5'd16},
    '{12'd9,  2'd1, 8'd2, 5'd1}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + 32'(i);
    clr_cnt();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mreq_valid, "R1 idle after reset", {busy, mreq_valid}, 0);
    chk({sof_flag, eof_flag, ufl_flag} == 0, "R1 flags clear", {sof_flag, eof_flag, ufl_flag}, 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R7 R8 R10
    eof_ie = 1;
    for (int i = 0; i < 6; i++) begin
      put_desc(0, 32'h40, 32'h100, 32'hA0 + 32'(i), 32'(VECS[i].len) | (32'h1 << 16));
      burst_sel = VECS[i].sel; start_addr = 0;
      clr_cnt(); fill_exp(0, 32'h100, int'(VECS[i].len));
      kick(); wait_idle();
      chk(px_n == int'(VECS[i].len), "R5 word count", px_n, VECS[i].len);
      chk(px_bad == 0, "R5 word order", px_bad, 0);
      chk(bursts == int'(VECS[i].nb), "R3 burst count", bursts, VECS[i].nb);
      chk(last_len == int'(VECS[i].last), "R4 final burst length", last_len, VECS[i].last);
      chk(src_addr_q == 32'h100 && frame_id_q == 32'hA0 + 32'(i), "R2 latched fields", frame_id_q, 32'hA0 + i);
      chk(cmd_q[11:0] == VECS[i].len, "R2 command latched", cmd_q, VECS[i].len);
      chk(desc_addr_q == 32'h40, "R7 link followed", desc_addr_q, 32'h40);
      chk(eof_flag, "R8 end-of-frame flag", eof_flag, 1);
      pulse_clr(1);
      chk(!eof_flag, "R10 clear", eof_flag, 0);
    end

    // R8: enables gate the flags, start-of-frame requested
    eof_ie = 0; sof_ie = 0; burst_sel = 0;
    put_desc(0, 32'h40, 32'h100, 32'h1, 32'd4 | (32'h3 << 15));
    clr_cnt(); fill_exp(0, 32'h100, 4); kick(); wait_idle();
    chk(!sof_flag && !eof_flag, "R8 disabled enables", {sof_flag, eof_flag}, 0);
    sof_ie = 1;
    clr_cnt(); kick(); wait_idle();
    chk(sof_flag, "R8 start-of-frame flag", sof_flag, 1);
    chk(sof_flag && !eof_flag, "R10 sticky until clear", {sof_flag, eof_flag}, 2);
    pulse_clr(0);
    chk(!sof_flag, "R10 sof clear", sof_flag, 0);

    // R6 FIFO room boundary
    put_desc(0, 32'h40, 32'h100, 32'h2, 32'd8);
    fifo_free = 3; clr_cnt(); fill_exp(0, 32'h100, 8); kick();
    repeat (30) @(negedge clk);
    chk(bursts == 0 && busy, "R6 wait for room", bursts, 0);
    fifo_free = 4;
    wait_idle();
    chk(bursts == 2 && px_n == 8 && px_bad == 0, "R6 proceeds with room", bursts, 2);
    fifo_free = 32;

    // R9 underrun
    ufl_ie = 0; fifo_empty = 1;
    clr_cnt(); kick(); wait_idle();
    chk(!ufl_flag, "R9 underrun masked", ufl_flag, 0);
    ufl_ie = 1;
    clr_cnt(); kick(); wait_idle();
    fifo_empty = 0;
    chk(ufl_flag, "R9 underrun flagged", ufl_flag, 1);
    pulse_clr(2);
    chk(!ufl_flag, "R9 underrun cleared", ufl_flag, 0);

    // R10 set and clear in the same cycle: set wins
    eof_ie = 1; clr_eof = 1;
    put_desc(0, 32'h40, 32'h100, 32'h3, 32'd6 | (32'h1 << 16));
    clr_cnt(); fill_exp(0, 32'h100, 6); kick(); wait_idle();
    @(negedge clk);
    chk(eof_seen == 1, "R10 set wins over clear", eof_seen, 1);
    chk(!eof_flag, "R10 cleared afterwards", eof_flag, 0);
    clr_eof = 0;

    // R11 pixel back-pressure
    burst_sel = 1;
    put_desc(0, 32'h40, 32'h100, 32'h4, 32'd13);
    clr_cnt(); fill_exp(0, 32'h100, 13); bp_mode = 1; kick(); wait_idle();
    bp_mode = 0; px_rdy = 1;
    chk(px_n == 13 && px_bad == 0, "R11 stall keeps words", px_bad, 0);

    // R7 R12 self-linked record repeats
    burst_sel = 0; start_addr = 32'h20;
    put_desc(32'h20, 32'h20, 32'h100, 32'h5, 32'd4);
    clr_cnt(); order_mod = 4;
    for (int f = 0; f < 5; f++) fill_exp(f * 4, 32'h100, 4);
    @(negedge clk) enable = 1;
    begin
      int n = 0;
      while (px_n < 12 && n < 2000) begin @(negedge clk); n++; end
    end
    enable = 0; wait_idle();
    chk(px_n == 12 && px_bad == 0, "R7 self loop repeats frame", px_n, 12);
    chk(desc_reqs == 3, "R12 stops at frame boundary", desc_reqs, 3);
    chk(order_bad == 0, "R7 record after last word", order_bad, 0);
    chk(desc_addr_q == 32'h20, "R12 start address used", desc_addr_q, 32'h20);

    // R7 R12 two-record chain
    start_addr = 32'h10;
    put_desc(32'h10, 32'h30, 32'h100, 32'h6, 32'd5);
    put_desc(32'h30, 32'h40, 32'h200, 32'h7, 32'd3 | (32'h1 << 15));
    clr_cnt(); fill_exp(0, 32'h100, 5); fill_exp(5, 32'h200, 3);
    @(negedge clk) enable = 1;
    begin
      int n = 0;
      while (desc_reqs < 2 && n < 2000) begin @(negedge clk); n++; end
    end
    enable = 0; wait_idle();
    chk(px_n == 8 && px_bad == 0, "R7 chain data", px_bad, 0);
    chk(frame_id_q == 32'h7 && desc_addr_q == 32'h40, "R7 second record", frame_id_q, 7);
    chk(sof_flag, "R8 sof on second record", sof_flag, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule